// File: doc/BRIEF.md
# Serial EEPROM Bus Control and Status Register

This block holds an 8-bit control and status byte for a two-wire serial bus master that can also pull register defaults out of an attached serial EEPROM. Around the byte sits a small sequencer. In the first clock after reset it samples the EEPROM presence input exactly once. When an EEPROM is present, the sequencer marks the interface enabled and launches the automatic default download on the serial engine. After that, software can issue its own serial cycles through a valid/ready request port.

The bit-level serial engine is not part of the block. It sits behind a start/done/error handshake. `eng_start` pulses for one cycle, and `eng_load` tells the engine whether the cycle is the EEPROM download (1) or a software cycle (0). The engine later returns a one-cycle `eng_done`, together with `eng_err` when the cycle failed.

The request port follows these back-pressure rules:
- A request is taken only in a cycle where `sw_req_valid` and `sw_req_ready` are both 1.
- `sw_req_ready` is high only when the interface is enabled and neither a download nor a software cycle is in flight.
- A requester may keep `sw_req_valid` asserted for as long as it likes without effect while ready is low.

A clock divider produces the serial bit-rate tick. It uses a normal rate or a faster test rate, chosen by a control bit.

Top module: `serial_ctl_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `reg_rd_data` reads 00h, and `eng_start` and `ser_tick` are 0.
- R2: Bit 6 always reads 0. Writes have no effect on bits 6, 5, 4, 1 and 0.
- R3: Bits 7 (address mode), 3 (interface enable) and 2 (test clock) read back the value last written by `reg_wr_en`.
- R4: In the first cycle after reset, `eeprom_present` is sampled. If it is 1, then in the next cycle bit 3 and bit 4 read 1, and `eng_start` pulses with `eng_load`=1. Bit 4 stays 1 until `eng_done`. `eeprom_present` has no effect at any other time.
- R5: If no EEPROM was sampled, bit 3 stays 0 and no download starts. Writing 1 to bit 3 later enables the interface without ever starting a download (bit 4 stays 0, no `eng_start`).
- R6: `sw_req_ready` is 1 only when bit 3 is 1 and bits 4 and 5 are 0. An accepted request produces, in the next cycle, an `eng_start` pulse with `eng_load`=0 and bit 5 = 1. Bit 5 returns to 0 in the cycle after `eng_done`.
- R7: An `eng_done` with `eng_err` sets bit 1 when it ends a software cycle, and sets bit 0 when it ends the download.
- R8: A cycle with `reg_rd_en` clears bits 1 and 0 from the next cycle on. The value shown during the read is the pre-clear value. When an error set and a read fall in the same cycle, the bit ends up set.
- R9: `eng_addr_only` equals bit 7 (1 = target address only, 0 = target address then byte address).
- R10: `ser_tick` pulses once every NORM_DIV cycles when bit 2 is 0, and once every TEST_DIV cycles when bit 2 is 1.
- R11: `eng_done`/`eng_err` arriving while no cycle is in flight change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_en | input | 1 | Register read strobe (clears error bits) |
| reg_rd_data | output | 8 | Current register value |
| eeprom_present | input | 1 | EEPROM presence indication, sampled once after reset |
| sw_req_valid | input | 1 | Software serial cycle request valid |
| sw_req_ready | output | 1 | Software request can be accepted |
| eng_start | output | 1 | One-cycle start pulse to the serial engine |
| eng_load | output | 1 | Current engine cycle is the EEPROM download |
| eng_addr_only | output | 1 | Send target address only |
| eng_done | input | 1 | Engine cycle finished |
| eng_err | input | 1 | Engine cycle failed (valid with eng_done) |
| ser_tick | output | 1 | Serial bit-rate tick |

## Verification
Several properties are checked by the assertions on every cycle:
- the reserved bit is zero;
- the two busy flags are never both high;
- ready implies enabled and idle;
- every accepted request starts a non-download engine cycle;
- a rising download flag coincides with a download start;
- a read without a coinciding done leaves the error bits clear;
- a stray done while idle leaves the error bits unchanged.

Other behaviours can only be shown by the bench's scenarios:
- detection happening once per reset, and being ignored later;
- the forced enable that starts no download;
- set-wins on a same-cycle read;
- the exact tick periods at both rates.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;
  localparam int REG_W      = 8;
  localparam int BIT_ADDR1  = 7;
  localparam int BIT_RSVD   = 6;
  localparam int BIT_SWBUSY = 5;
  localparam int BIT_LDBUSY = 4;
  localparam int BIT_ENABLE = 3;
  localparam int BIT_FAST   = 2;
  localparam int BIT_SWERR  = 1;
  localparam int BIT_LDERR  = 0;

  typedef enum logic [1:0] {
    ST_DETECT = 2'd0,
    ST_LOAD   = 2'd1,
    ST_IDLE   = 2'd2,
    ST_SW     = 2'd3
  } seq_state_t;
endpackage

// File: rtl/serial_ctl_seq.sv
module serial_ctl_seq
  import serial_ctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic present,
  input  logic if_en,
  input  logic req_valid,
  output logic req_ready,
  input  logic done,
  input  logic err,
  output logic start,
  output logic load,
  output logic sw_busy,
  output logic ld_busy,
  output logic det_set,
  output logic sw_err_set,
  output logic ld_err_set
);
  seq_state_t state;
  logic start_q, load_q;

  assign req_ready  = (state == ST_IDLE) && if_en;
  assign det_set    = (state == ST_DETECT) && present;
  assign sw_err_set = (state == ST_SW) && done && err;
  assign ld_err_set = (state == ST_LOAD) && done && err;
  assign sw_busy    = (state == ST_SW);
  assign ld_busy    = (state == ST_LOAD);
  assign start      = start_q;
  assign load       = load_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_DETECT;
      start_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      case (state)
        ST_DETECT: begin
          if (present) begin
            state   <= ST_LOAD;
            start_q <= 1'b1;
            load_q  <= 1'b1;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_LOAD: if (done) state <= ST_IDLE;
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            state   <= ST_SW;
            start_q <= 1'b1;
            load_q  <= 1'b0;
          end
        end
        ST_SW:   if (done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
  import serial_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic             det_set,
  input  logic             sw_err_set,
  input  logic             ld_err_set,
  input  logic             sw_busy,
  input  logic             ld_busy,
  output logic [REG_W-1:0] value,
  output logic             addr_only,
  output logic             if_en,
  output logic             fast
);
  logic sw_err, ld_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_only <= 1'b0;
      if_en     <= 1'b0;
      fast      <= 1'b0;
    end else begin
      if (wr_en) begin
        addr_only <= wr_data[BIT_ADDR1];
        if_en     <= wr_data[BIT_ENABLE];
        fast      <= wr_data[BIT_FAST];
      end
      if (det_set) if_en <= 1'b1;
    end
  end

  // Error flags: a hardware set has priority over the clearing read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_err <= 1'b0;
      ld_err <= 1'b0;
    end else begin
      if (sw_err_set)  sw_err <= 1'b1;
      else if (rd_en)  sw_err <= 1'b0;
      if (ld_err_set)  ld_err <= 1'b1;
      else if (rd_en)  ld_err <= 1'b0;
    end
  end

  always_comb begin
    value             = '0;
    value[BIT_ADDR1]  = addr_only;
    value[BIT_RSVD]   = 1'b0;
    value[BIT_SWBUSY] = sw_busy;
    value[BIT_LDBUSY] = ld_busy;
    value[BIT_ENABLE] = if_en;
    value[BIT_FAST]   = fast;
    value[BIT_SWERR]  = sw_err;
    value[BIT_LDERR]  = ld_err;
  end
endmodule

// File: rtl/serial_ctl_clkdiv.sv
module serial_ctl_clkdiv #(
  parameter int NORM_DIV = 250,
  parameter int TEST_DIV = 4,
  parameter int CNT_W    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit = fast ? CNT_W'(TEST_DIV - 1) : CNT_W'(NORM_DIV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt >= limit);
      if (cnt >= limit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/serial_ctl_top.sv
module serial_ctl_top
  import serial_ctl_pkg::*;
#(
  parameter int NORM_DIV = 250,
  parameter int TEST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  input  logic             reg_rd_en,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             eeprom_present,
  input  logic             sw_req_valid,
  output logic             sw_req_ready,
  output logic             eng_start,
  output logic             eng_load,
  output logic             eng_addr_only,
  input  logic             eng_done,
  input  logic             eng_err,
  output logic             ser_tick
);
  localparam int MAX_DIV = (NORM_DIV > TEST_DIV) ? NORM_DIV : TEST_DIV;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic if_en, fast, sw_busy, ld_busy;
  logic det_set, sw_err_set, ld_err_set;

  serial_ctl_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .present    (eeprom_present),
    .if_en      (if_en),
    .req_valid  (sw_req_valid),
    .req_ready  (sw_req_ready),
    .done       (eng_done),
    .err        (eng_err),
    .start      (eng_start),
    .load       (eng_load),
    .sw_busy    (sw_busy),
    .ld_busy    (ld_busy),
    .det_set    (det_set),
    .sw_err_set (sw_err_set),
    .ld_err_set (ld_err_set)
  );

  serial_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .wr_data    (reg_wr_data),
    .rd_en      (reg_rd_en),
    .det_set    (det_set),
    .sw_err_set (sw_err_set),
    .ld_err_set (ld_err_set),
    .sw_busy    (sw_busy),
    .ld_busy    (ld_busy),
    .value      (reg_rd_data),
    .addr_only  (eng_addr_only),
    .if_en      (if_en),
    .fast       (fast)
  );

  serial_ctl_clkdiv #(
    .NORM_DIV (NORM_DIV),
    .TEST_DIV (TEST_DIV),
    .CNT_W    (CNT_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .fast  (fast),
    .tick  (ser_tick)
  );
endmodule

// File: rtl/serial_ctl_chk.sv
module serial_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd_en,
  input logic [7:0] reg_rd_data,
  input logic       sw_req_valid,
  input logic       sw_req_ready,
  input logic       eng_start,
  input logic       eng_load,
  input logic       eng_done,
  input logic       eng_err
);
  // R2
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[6] == 1'b0);

  // R6
  a_r6_busy_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_data[5] && reg_rd_data[4]));

  // R6
  a_r6_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_ready |-> (reg_rd_data[3] && !reg_rd_data[5] && !reg_rd_data[4]));

  // R6
  a_r6_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req_valid && sw_req_ready) |=> (eng_start && !eng_load && reg_rd_data[5]));

  // R4
  a_r4_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rd_data[4]) |-> (eng_start && eng_load));

  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !eng_done) |=> (reg_rd_data[1:0] == 2'b00));

  // R11
  a_r11_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_err && !reg_rd_data[5] && !reg_rd_data[4] && !reg_rd_en)
      |=> $stable(reg_rd_data[1:0]));
endmodule

bind serial_ctl_top serial_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_rd_en    (reg_rd_en),
  .reg_rd_data  (reg_rd_data),
  .sw_req_valid (sw_req_valid),
  .sw_req_ready (sw_req_ready),
  .eng_start    (eng_start),
  .eng_load     (eng_load),
  .eng_done     (eng_done),
  .eng_err      (eng_err)
);

// File: tb/serial_ctl_top_test.sv
module serial_ctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDIV = 250;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic       reg_rd_en = 1'b0;
  logic [7:0] reg_rd_data;
  logic       eeprom_present = 1'b0;
  logic       sw_req_valid = 1'b0;
  logic       sw_req_ready;
  logic       eng_start, eng_load, eng_addr_only;
  logic       eng_done = 1'b0;
  logic       eng_err = 1'b0;
  logic       ser_tick;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_top #(.NORM_DIV(NDIV), .TEST_DIV(TDIV)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data),
    .eeprom_present(eeprom_present),
    .sw_req_valid(sw_req_valid), .sw_req_ready(sw_req_ready),
    .eng_start(eng_start), .eng_load(eng_load), .eng_addr_only(eng_addr_only),
    .eng_done(eng_done), .eng_err(eng_err), .ser_tick(ser_tick)
  );

  // Written value / expected read-back, interface disabled, no EEPROM.
  localparam logic [7:0] WV [0:7] = '{8'hFF, 8'h00, 8'h80, 8'h04, 8'h08, 8'h73, 8'h8C, 8'h00};
  localparam logic [7:0] EV [0:7] = '{8'h8C, 8'h00, 8'h80, 8'h04, 8'h08, 8'h00, 8'h8C, 8'h00};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [7:0] d);
    reg_wr_en = 1'b1;
    reg_wr_data = d;
    cyc();
    reg_wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic present);
    @(negedge clk);
    rst_n = 1'b0;
    eeprom_present = present;
    cyc();
    check("R1 reset value", reg_rd_data, 8'h00);
    check("R1 no start in reset", eng_start, 1'b0);
    check("R1 no tick in reset", ser_tick, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic measure_period(input int exp, input string req);
    int n = 0;
    while (ser_tick !== 1'b1 && n < 1000) begin cyc(); n++; end
    cyc();
    n = 1;
    while (ser_tick !== 1'b1 && n < 1000) begin cyc(); n++; end
    check(req, n, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // No EEPROM: register walk
    do_reset(1'b0);
    check("R1 first cycle after reset", reg_rd_data, 8'h00);
    cyc();
    check("R5 no detect keeps enable low", reg_rd_data[3], 1'b0);
    for (int i = 0; i < 8; i++) begin
      write_reg(WV[i]);
      check("R2 R3 write read-back", reg_rd_data, EV[i]);
      check("R9 address-mode output", eng_addr_only, EV[i][7]);
      check("R5 no download on enable write", eng_start, 1'b0);
    end

    // R5: forced enable, no download, request accepted as software cycle
    write_reg(8'h08);
    check("R5 forced enable, not loading", reg_rd_data[4], 1'b0);
    sw_req_valid = 1'b1;
    #1;
    check("R6 ready when enabled", sw_req_ready, 1'b1);
    cyc();
    sw_req_valid = 1'b0;
    check("R6 start pulse", eng_start, 1'b1);
    check("R6 start not load", eng_load, 1'b0);
    check("R6 sw busy", reg_rd_data[5], 1'b1);
    check("R6 ready low while busy", sw_req_ready, 1'b0);
    cyc();
    check("R6 start is one cycle", eng_start, 1'b0);
    eng_done = 1'b1; eng_err = 1'b1;
    cyc();
    eng_done = 1'b0; eng_err = 0;
    check("R7 sw error set", reg_rd_data, 8'h0A);
    reg_rd_en = 1'b1;
    #1;
    check("R8 read shows pre-clear", reg_rd_data, 8'h0A);
    cyc();
    reg_rd_en = 1'b0;
    check("R8 read clears", reg_rd_data, 8'h08);

    // R11: stray done while idle
    eng_done = 1'b1; eng_err = 1'b1;
    cyc();
    eng_done = 1'b0; eng_err = 1'b0;
    check("R11 stray done ignored", reg_rd_data, 8'h08);

    // R8 set wins over same-cycle read
    sw_req_valid = 1'b1;
    cyc();
    sw_req_valid = 1'b0;
    eng_done = 1'b1; eng_err = 1'b1; reg_rd_en = 1'b1;
    cyc();
    eng_done = 1'b0; eng_err = 1'b0; reg_rd_en = 1'b0;
    check("R8 set wins over read", reg_rd_data, 8'h0A);
    reg_rd_en = 1'b1;
    cyc();
    reg_rd_en = 1'b0;
    check("R8 cleared after second read", reg_rd_data, 8'h08);

    // R10 tick periods
    write_reg(8'h0C);
    measure_period(TDIV, "R10 test rate period");
    write_reg(8'h08);
    measure_period(NDIV, "R10 normal rate period");

    // EEPROM present: detection and download
    do_reset(1'b1);
    check("R1 first cycle after reset", reg_rd_data, 8'h00);
    check("R1 no start first cycle", eng_start, 1'b0);
    cyc();
    check("R4 detect and loading", reg_rd_data, 8'h18);
    check("R4 load start pulse", eng_start, 1'b1);
    check("R4 load flag", eng_load, 1'b1);
    sw_req_valid = 1'b1;
    #1;
    check("R6 held off while loading", sw_req_ready, 1'b0);
    cyc();
    sw_req_valid = 1'b0;
    check("R6 no start while loading", eng_start, 1'b0);
    check("R4 still loading", reg_rd_data[4], 1'b1);
    eng_done = 1'b1; eng_err = 1'b1;
    cyc();
    eng_done = 1'b0; eng_err = 1'b0;
    check("R7 load error set", reg_rd_data, 8'h09);
    reg_rd_en = 1'b1;
    cyc();
    reg_rd_en = 1'b0;
    check("R8 load error cleared", reg_rd_data, 8'h08);

    // Detection only once: presence toggles and enable cleared
    write_reg(8'h00);
    eeprom_present = 1'b0;
    cyc();
    eeprom_present = 1'b1;
    cyc(); cyc();
    check("R4 presence ignored later", reg_rd_data, 8'h00);
    check("R4 no second download", eng_start, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule